// File: doc/BRIEF.md
# Dual-Width Stack Pointer Unit

This unit keeps the stack pointer of a small processor and turns push and pop requests into memory accesses. The pointer has two widths. With the mode bit of the system control byte cleared, only the low pointer byte forms the address, so the stack lives in the first 256 bytes and wraps inside them. With the mode bit set, the high and low bytes together form a 16-bit pointer, and carries and borrows pass between them.

A push decrements the pointer and then writes the pushed byte at the new pointer in the same cycle. A pop reads at the current pointer and then increments it. The memory answers one cycle after the read strobe, and the unit hands the byte back in that cycle with a valid flag. The control byte and the two pointer bytes are also written and read as memory-mapped bytes through a small configuration port.

FSM states: `ST_IDLE` takes requests. `ST_POP_WAIT` waits for the memory's answer. The transitions are `ST_IDLE -> ST_POP_WAIT` on a pop that is taken, `ST_POP_WAIT -> ST_IDLE` always, and `ST_IDLE -> ST_IDLE` on a push or on no request.

Top module: `sp_unit`

## Requirements
- R1: After reset the control byte (address 0x19) and both pointer bytes (0x1C high, 0x1D low) read 0x00, the unit is in 8-bit mode, and `busy` is low.
- R2: A configuration write to 0x19, 0x1C or 0x1D stores the byte, and a read at that address returns it. Writes to any other address change nothing, and reads there return 0x00.
- R3: In 8-bit mode (bit 6 of the control byte is 0), a push asserts `mem_we` with `mem_wdata` set to the pushed byte, at address {0x00, low-1}. The low byte becomes low-1 and wraps from 0x00 to 0xFF.
- R4: In 8-bit mode a pop asserts `mem_re` at address {0x00, low} and the low byte becomes low+1, wrapping from 0xFF to 0x00. In the next cycle `pop_valid` is high and `pop_data` carries `mem_rdata`.
- R5: In 8-bit mode the high pointer byte has no effect on `mem_addr`, and stack operations never change it.
- R6: In 16-bit mode (bit 6 set), a push decrements the full 16-bit pointer, with the borrow reaching the high byte, and writes at the new pointer.
- R7: In 16-bit mode a pop reads at the full pointer and then increments it, with the carry reaching the high byte.
- R8: When push and pop are requested in the same idle cycle, only the push is performed.
- R9: While `busy` is high (the cycle after a pop), requests are ignored: no memory strobe is raised and the pointer does not change.
- R10: When a stack operation writes back a pointer byte in the same cycle as a configuration write to that byte, the stack value is kept. In 8-bit mode a configuration write to the high byte during a push still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| rd_addr | input | 8 | Configuration read address |
| rd_data | output | 8 | Byte at `rd_addr` (combinational) |
| push_req | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop request |
| busy | output | 1 | Pop answer pending; requests ignored |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, one cycle after `mem_re` |
| pop_valid | output | 1 | `pop_data` holds the popped byte |
| pop_data | output | 8 | Popped byte |

## Verification
The hardest cases to reach are the cycles where two writers want the same pointer byte: a configuration write to the low byte during a push, and a write to the high byte during an 8-bit push, where the configuration write has to win. The bench drives the configuration strobe and the push request on the same falling edge, then reads both pointer bytes back through the read port. A request that lands in the pop wait cycle is reached the same way: the bench keeps a push asserted in the cycle right after a pop and checks that no write strobe appears and that the pointer holds.

// File: rtl/sp_unit_pkg.sv
package sp_unit_pkg;

    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_POP_WAIT = 1'b1
    } sp_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } sp_op_e;

endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
    import sp_unit_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_req,
    input  logic   pop_req,
    output sp_op_e op,
    output logic   busy,
    output logic   pop_valid
);

    sp_state_e state_q;
    sp_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and next state
    always_comb begin
        state_d   = state_q;
        op        = OP_NONE;
        busy      = 1'b0;
        pop_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (push_req) begin
                    op = OP_PUSH;
                end else if (pop_req) begin
                    op      = OP_POP;
                    state_d = ST_POP_WAIT;
                end
            end
            ST_POP_WAIT: begin
                busy      = 1'b1;
                pop_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sp_step.sv
module sp_step
    import sp_unit_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
) (
    input  sp_op_e              op,
    input  logic                wide,
    input  logic [BYTE_W-1:0]   ptr_hi,
    input  logic [BYTE_W-1:0]   ptr_lo,
    output logic [PTR_W-1:0]    access_addr,
    output logic [PTR_W-1:0]    next_ptr,
    output logic [1:0]          byte_we
);

    logic [PTR_W-1:0]  full_ptr;
    logic [PTR_W-1:0]  full_dec;
    logic [PTR_W-1:0]  full_inc;
    logic [BYTE_W-1:0] lo_dec;
    logic [BYTE_W-1:0] lo_inc;

    assign full_ptr = {ptr_hi, ptr_lo};
    assign full_dec = full_ptr - {{(PTR_W-1){1'b0}}, 1'b1};
    assign full_inc = full_ptr + {{(PTR_W-1){1'b0}}, 1'b1};
    assign lo_dec   = ptr_lo - {{(BYTE_W-1){1'b0}}, 1'b1};
    assign lo_inc   = ptr_lo + {{(BYTE_W-1){1'b0}}, 1'b1};

    always_comb begin
        access_addr = '0;
        next_ptr    = full_ptr;
        byte_we     = 2'b00;
        unique case (op)
            OP_PUSH: begin
                if (wide) begin
                    next_ptr    = full_dec;
                    access_addr = full_dec;
                    byte_we     = 2'b11;
                end else begin
                    next_ptr    = {ptr_hi, lo_dec};
                    access_addr = {{BYTE_W{1'b0}}, lo_dec};
                    byte_we     = 2'b01;
                end
            end
            OP_POP: begin
                if (wide) begin
                    next_ptr    = full_inc;
                    access_addr = full_ptr;
                    byte_we     = 2'b11;
                end else begin
                    next_ptr    = {ptr_hi, lo_inc};
                    access_addr = {{BYTE_W{1'b0}}, ptr_lo};
                    byte_we     = 2'b01;
                end
            end
            default: begin
                byte_we = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/sp_regs.sv
module sp_regs #(
    parameter int                BYTE_W     = 8,
    parameter int                CFG_AW     = 8,
    parameter int                MODE_BIT   = 6,
    parameter logic [CFG_AW-1:0] REG_SYS    = 8'h19,
    parameter logic [CFG_AW-1:0] REG_PTR_HI = 8'h1C,
    parameter logic [CFG_AW-1:0] REG_PTR_LO = 8'h1D,
    localparam int               PTR_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic [CFG_AW-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        stack_we,
    input  logic [PTR_W-1:0]  stack_ptr,
    output logic [BYTE_W-1:0] ptr_hi,
    output logic [BYTE_W-1:0] ptr_lo,
    output logic              wide
);

    logic [BYTE_W-1:0] sys_q;
    logic [BYTE_W-1:0] ptr_byte [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q <= '0;
        end else if (cfg_we && (cfg_addr == REG_SYS)) begin
            sys_q <= cfg_wdata;
        end
    end

    // index 0 is the low byte, index 1 the high byte
    for (genvar gi = 0; gi < 2; gi++) begin : g_ptr_byte
        localparam logic [CFG_AW-1:0] MY_ADDR = (gi == 0) ? REG_PTR_LO : REG_PTR_HI;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_byte[gi] <= '0;
            end else if (stack_we[gi]) begin
                ptr_byte[gi] <= stack_ptr[gi*BYTE_W +: BYTE_W];
            end else if (cfg_we && (cfg_addr == MY_ADDR)) begin
                ptr_byte[gi] <= cfg_wdata;
            end
        end
    end

    assign ptr_lo = ptr_byte[0];
    assign ptr_hi = ptr_byte[1];
    assign wide   = sys_q[MODE_BIT];

    always_comb begin
        if (rd_addr == REG_SYS) begin
            rd_data = sys_q;
        end else if (rd_addr == REG_PTR_HI) begin
            rd_data = ptr_byte[1];
        end else if (rd_addr == REG_PTR_LO) begin
            rd_data = ptr_byte[0];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/sp_unit.sv
module sp_unit
    import sp_unit_pkg::*;
#(
    parameter int                BYTE_W     = 8,
    parameter int                CFG_AW     = 8,
    parameter int                MODE_BIT   = 6,
    parameter logic [CFG_AW-1:0] REG_SYS    = 8'h19,
    parameter logic [CFG_AW-1:0] REG_PTR_HI = 8'h1C,
    parameter logic [CFG_AW-1:0] REG_PTR_LO = 8'h1D,
    localparam int               PTR_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic [CFG_AW-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              push_req,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop_req,
    output logic              busy,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data
);

    sp_op_e            op;
    logic              wide_mode;
    logic [BYTE_W-1:0] ptr_hi;
    logic [BYTE_W-1:0] ptr_lo;
    logic [PTR_W-1:0]  next_ptr;
    logic [1:0]        byte_we;

    sp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .op        (op),
        .busy      (busy),
        .pop_valid (pop_valid)
    );

    sp_step #(.BYTE_W(BYTE_W)) u_step (
        .op          (op),
        .wide        (wide_mode),
        .ptr_hi      (ptr_hi),
        .ptr_lo      (ptr_lo),
        .access_addr (mem_addr),
        .next_ptr    (next_ptr),
        .byte_we     (byte_we)
    );

    sp_regs #(
        .BYTE_W     (BYTE_W),
        .CFG_AW     (CFG_AW),
        .MODE_BIT   (MODE_BIT),
        .REG_SYS    (REG_SYS),
        .REG_PTR_HI (REG_PTR_HI),
        .REG_PTR_LO (REG_PTR_LO)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .stack_we  (byte_we),
        .stack_ptr (next_ptr),
        .ptr_hi    (ptr_hi),
        .ptr_lo    (ptr_lo),
        .wide      (wide_mode)
    );

    assign mem_we    = (op == OP_PUSH);
    assign mem_re    = (op == OP_POP);
    assign mem_wdata = mem_we ? push_data : '0;
    assign pop_data  = pop_valid ? mem_rdata : '0;

endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
    parameter int                BYTE_W     = 8,
    parameter int                CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] REG_PTR_HI = 8'h1C,
    localparam int               PTR_W      = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic [PTR_W-1:0]  mem_addr,
    input logic              pop_valid,
    input logic              busy,
    input logic              wide,
    input logic [BYTE_W-1:0] ptr_hi,
    input logic [BYTE_W-1:0] ptr_lo
);

    // R8
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R5
    narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !wide) |-> (mem_addr[PTR_W-1:BYTE_W] == '0));

    // R3
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr_lo == $past(mem_addr[BYTE_W-1:0])));

    // R4
    pop_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> pop_valid);

    // R4
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (ptr_lo == ($past(mem_addr[BYTE_W-1:0]) + {{(BYTE_W-1){1'b0}}, 1'b1})));

    // R5
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !wide && !(cfg_we && (cfg_addr == REG_PTR_HI)))
        |=> $stable(ptr_hi));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_we && !mem_re));

endmodule

bind sp_unit sp_unit_chk #(
    .BYTE_W     (BYTE_W),
    .CFG_AW     (CFG_AW),
    .REG_PTR_HI (REG_PTR_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .pop_valid (pop_valid),
    .busy      (busy),
    .wide      (wide_mode),
    .ptr_hi    (ptr_hi),
    .ptr_lo    (ptr_lo)
);

// File: tb/sp_unit_tb_top.sv
module sp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        push_req = 1'b0;
    logic [7:0]  push_data = '0;
    logic        pop_req = 1'b0;
    logic        busy;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        pop_valid;
    logic [7:0]  pop_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sp_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .push_req  (push_req),
        .push_data (push_data),
        .pop_req   (pop_req),
        .busy      (busy),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pop_valid (pop_valid),
        .pop_data  (pop_data)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    // memory model: answers one cycle after the read strobe
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_byte(mem_addr);
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_sp(output logic [15:0] v);
        rd_addr = 8'h1C;
        #1;
        v[15:8] = rd_data;
        rd_addr = 8'h1D;
        #1;
        v[7:0] = rd_data;
    endtask

    // {req, op, cfg addr, data, expected mem_addr, expected pointer}
    // op: 0 config write, 1 push, 2 pop, 3 push and pop together
    localparam int NV = 21;
    localparam logic [53:0] VEC [NV] = '{
        {4'd3, 2'd1, 8'h00, 8'hAA, 16'h00FF, 16'h00FF}, // R3 wrap 00->FF
        {4'd3, 2'd1, 8'h00, 8'hBB, 16'h00FE, 16'h00FE}, // R3
        {4'd4, 2'd2, 8'h00, 8'h00, 16'h00FE, 16'h00FF}, // R4
        {4'd4, 2'd2, 8'h00, 8'h00, 16'h00FF, 16'h0000}, // R4 wrap FF->00
        {4'd4, 2'd2, 8'h00, 8'h00, 16'h0000, 16'h0001}, // R4
        {4'd2, 2'd0, 8'h1C, 8'h12, 16'h0000, 16'h1201}, // R2
        {4'd5, 2'd1, 8'h00, 8'h33, 16'h0000, 16'h1200}, // R5
        {4'd5, 2'd1, 8'h00, 8'h44, 16'h00FF, 16'h12FF}, // R5 high byte kept
        {4'd2, 2'd0, 8'h19, 8'h40, 16'h0000, 16'h12FF}, // R2 enter 16-bit
        {4'd6, 2'd1, 8'h00, 8'h55, 16'h12FE, 16'h12FE}, // R6
        {4'd2, 2'd0, 8'h1D, 8'h00, 16'h0000, 16'h1200}, // R2
        {4'd6, 2'd1, 8'h00, 8'h66, 16'h11FF, 16'h11FF}, // R6 borrow
        {4'd7, 2'd2, 8'h00, 8'h00, 16'h11FF, 16'h1200}, // R7 carry
        {4'd2, 2'd0, 8'h1D, 8'hFF, 16'h0000, 16'h12FF}, // R2
        {4'd7, 2'd2, 8'h00, 8'h00, 16'h12FF, 16'h1300}, // R7 carry
        {4'd8, 2'd3, 8'h00, 8'h77, 16'h12FF, 16'h12FF}, // R8 push wins
        {4'd2, 2'd0, 8'h1D, 8'h00, 16'h0000, 16'h1200}, // R2
        {4'd2, 2'd0, 8'h1C, 8'h00, 16'h0000, 16'h0000}, // R2
        {4'd6, 2'd1, 8'h00, 8'h88, 16'hFFFF, 16'hFFFF}, // R6 full wrap
        {4'd7, 2'd2, 8'h00, 8'h00, 16'hFFFF, 16'h0000}, // R7 full wrap
        {4'd2, 2'd0, 8'h19, 8'h00, 16'h0000, 16'h0000}  // R2 back to 8-bit
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] sp;
        // R1 reset state
        repeat (2) @(negedge clk);
        rd_addr = 8'h19;
        #1;
        check("R1", {8'h00, rd_data}, 16'h0000, "control byte in reset");
        read_sp(sp);
        check("R1", sp, 16'h0000, "pointer in reset");
        check("R1", {15'd0, busy}, 16'h0000, "busy in reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  req;
            logic [1:0]  op;
            logic [7:0]  a, d;
            logic [15:0] ea, esp;
            string       rq;
            {req, op, a, d, ea, esp} = VEC[i];
            rq = $sformatf("R%0d", req);
            @(negedge clk);
            if (op == 2'd0) begin
                cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
            end else begin
                push_req  = op[0];
                pop_req   = op[1];
                push_data = d;
                #2;
                check(rq, mem_addr, ea, "mem_addr");
                if (op[0]) begin
                    check(rq, {15'd0, mem_we}, 16'd1, "mem_we");
                    check(rq, {8'h00, mem_wdata}, {8'h00, d}, "mem_wdata");
                end else begin
                    check(rq, {15'd0, mem_re}, 16'd1, "mem_re");
                end
            end
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0; push_req = 1'b0; pop_req = 1'b0;
            read_sp(sp);
            check(rq, sp, esp, "pointer");
            if (op == 2'd2) begin
                check(rq, {15'd0, pop_valid}, 16'd1, "pop_valid");
                check(rq, {8'h00, pop_data}, {8'h00, mem_byte(ea)}, "pop_data");
            end else if (op == 2'd3) begin
                check(rq, {15'd0, pop_valid}, 16'd0, "no pop when both");
            end
        end

        // R2 unmapped address ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h1A; cfg_wdata = 8'h5A;
        @(negedge clk);
        cfg_we = 1'b0;
        rd_addr = 8'h1A;
        #1;
        check("R2", {8'h00, rd_data}, 16'h0000, "unmapped read");
        read_sp(sp);
        check("R2", sp, 16'h0000, "pointer after unmapped write");

        // R9 request during pop wait ignored
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0; push_req = 1'b1; push_data = 8'h99;
        #2;
        check("R9", {15'd0, busy}, 16'd1, "busy in wait");
        check("R9", {15'd0, mem_we}, 16'd0, "no write in wait");
        @(negedge clk);
        push_req = 1'b0;
        read_sp(sp);
        check("R9", sp, 16'h0001, "pointer after ignored push");

        // R10 stack write-back beats config write to the low byte
        @(negedge clk);
        push_req = 1'b1; push_data = 8'h21;
        cfg_we = 1'b1; cfg_addr = 8'h1D; cfg_wdata = 8'h40;
        @(negedge clk);
        push_req = 1'b0; cfg_we = 1'b0;
        read_sp(sp);
        check("R10", sp, 16'h0000, "low byte collision");
        // R10 in 8-bit mode the high byte write still lands during a push
        @(negedge clk);
        push_req = 1'b1; push_data = 8'h22;
        cfg_we = 1'b1; cfg_addr = 8'h1C; cfg_wdata = 8'h7E;
        @(negedge clk);
        push_req = 1'b0; cfg_we = 1'b0;
        read_sp(sp);
        check("R10", sp, 16'h7EFF, "high byte during 8-bit push");

        // R1 reset in mid run
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h19; cfg_wdata = 8'h40;
        @(negedge clk);
        cfg_we = 1'b0;
        rst_n = 1'b0;
        #1;
        read_sp(sp);
        check("R1", sp, 16'h0000, "pointer after second reset");
        rd_addr = 8'h19;
        #1;
        check("R1", {8'h00, rd_data}, 16'h0000, "control after second reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule